// File: doc/BRIEF.md
# Parallel ATA Programmed-Strobe Timing Generator

This block drives the read and write strobes, register address and chip selects of one parallel ATA channel for programmed data cycles, multiword DMA data cycles and task-file register accesses. Each of the devices on the channel has its own 32-bit timing word. The word holds two independent sets of strobe timing: one for data cycles and one for register cycles. Each set has an active (strobe low) time, an inactive (recovery) time and a setup time. The setup time is inserted only ahead of the first strobe of a request.

A request names the device, the direction, whether it is a data burst or a register access, whether a data burst belongs to a DMA transfer, a word count, a register address and a chip-select choice. The block returns a one-cycle completion pulse, and for reads it returns each captured word with a valid pulse. The four mode-enable bits at the top of every timing word are exported unchanged. A flag shows whether the transfer FIFO is in use: only DMA data bursts engage it.

Top module: `pata_strobe_gen`

## Requirements
- R1: In a data burst, each strobe stays low for timing-word bits [8:4] plus one clock cycles.
- R2: In a data burst, the strobe stays high for bits [3:0] plus one cycles after each word. `rsp_done` is high for exactly one cycle, in the cycle after the last recovery phase ends.
- R3: In a register access, the strobe is low for bits [17:13] plus one cycles and the recovery lasts bits [12:9] plus one cycles.
- R4: A data burst waits bits [24:22] cycles (zero means none) after acceptance before its first strobe. Later words of the same burst get no setup.
- R5: A register access waits bits [27:25] cycles after acceptance before its strobe.
- R6: `req_dev` selects which device's timing word times the request. A write with `cfg_dev` = d changes only device d's word.
- R7: `flags_o[4*d+3:4*d]` equals bits [31:28] of device d's timing word from the cycle after it is written.
- R8: A request of `req_count` = N words produces N strobes, and N = 0 is run as a single word. Acceptance of a request to done takes setup + N×(active+recovery) cycles. `busy` is high from the cycle after acceptance through the done cycle.
- R9: On reads, `ata_din` is captured on the clock edge at which the strobe returns high. `rsp_rdata` holds the captured word and `rsp_rvalid` pulses once per word in the following cycle.
- R10: `fifo_on` is high only while a data burst flagged as DMA is in progress. It stays low for programmed data bursts and register accesses.
- R11: A timing-word write accepted while a request runs does not alter that request. It applies from the next request.
- R12: While busy, data cycles drive `ata_addr` = 0 and `ata_cs_n` = 2'b10. Register cycles drive `req_addr`, with `ata_cs_n` = 2'b10 when `req_csel` = 0 and 2'b01 when it is 1. Only the strobe matching the direction ever goes low. Writes drive `ata_dout` from `req_wdata`, with `ata_doe` high.
- R13: After reset and whenever idle, both strobes are high, `ata_cs_n` = 2'b11 and `busy`, `rsp_done`, `rsp_rvalid` and `fifo_on` are low. All timing words reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Timing-word write strobe |
| cfg_dev | input | DEV_W | Device whose timing word is written |
| cfg_word | input | 32 | New timing word |
| flags_o | output | 4*NUM_DEV | Mode-enable bits [31:28] of each device's word |
| req_valid | input | 1 | Request present; taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data | input | 1 | 1 = data burst, 0 = register access |
| req_dma | input | 1 | Data burst belongs to a DMA transfer |
| req_dev | input | DEV_W | Device selecting the timing word |
| req_count | input | CNT_W | Number of words (0 runs one) |
| req_addr | input | 3 | Register address for register accesses |
| req_csel | input | 1 | Register access uses the second chip select |
| req_wdata | input | DW | Write data, loaded at each strobe start |
| busy | output | 1 | Request in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rvalid | output | 1 | Read word captured |
| rsp_rdata | output | DW | Last captured read word |
| fifo_on | output | 1 | Transfer FIFO engaged |
| ata_addr | output | 3 | Register address pins |
| ata_cs_n | output | 2 | Active-low chip selects |
| ata_rd_n | output | 1 | Active-low read strobe |
| ata_wr_n | output | 1 | Active-low write strobe |
| ata_dout | output | DW | Data driven to the bus |
| ata_doe | output | 1 | Bus drive enable |
| ata_din | input | DW | Data from the bus |

## Verification
The assertions assume that `req_valid` is offered only while `busy` is low, or is otherwise simply left pending. They also assume that `cfg_dev` and `req_dev` name an existing device. The bench raises `req_valid` for exactly one cycle while the block is idle and waits for `rsp_done` before the next request, so no request ever overlaps. It changes the timing words either between requests or deliberately in the second cycle of a running burst. All inputs are driven on falling edges, so every value the assertions relate is stable across the rising edge.

// File: rtl/pata_strobe_pkg.sv
package pata_strobe_pkg;
  localparam int SETUP_W = 3;
  localparam int ACT_W   = 5;
  localparam int REC_W   = 4;
  localparam int TMR_W   = ACT_W;

  typedef struct packed {
    logic [SETUP_W-1:0] setup;
    logic [ACT_W-1:0]   act;
    logic [REC_W-1:0]   rec;
  } phase_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_SETUP, SQ_ACTIVE, SQ_RECOV, SQ_DONE
  } seq_state_t;

  // Data cycles and register cycles each own a field set in the word.
  function automatic phase_t pick_phase(input logic [31:0] w, input logic is_data);
    phase_t p;
    if (is_data) begin
      p.setup = w[24:22];
      p.act   = w[8:4];
      p.rec   = w[3:0];
    end else begin
      p.setup = w[27:25];
      p.act   = w[17:13];
      p.rec   = w[12:9];
    end
    return p;
  endfunction
endpackage

// File: rtl/pata_timing_bank.sv
module pata_timing_bank #(
  parameter int NUM_DEV = 2,
  localparam int DEV_W = $clog2(NUM_DEV)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [DEV_W-1:0]     cfg_dev,
  input  logic [31:0]          cfg_word,
  input  logic [DEV_W-1:0]     rd_dev,
  output logic [31:0]          rd_word,
  output logic [4*NUM_DEV-1:0] flags
);
  logic [31:0] words [NUM_DEV];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic [31:0] word_q;
    logic        wr_en;
    assign wr_en = cfg_we && (cfg_dev == DEV_W'(d));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_q <= '0;
      else if (wr_en) word_q <= cfg_word;
    end
    assign words[d]      = word_q;
    assign flags[4*d +: 4] = word_q[31:28];
  end

  assign rd_word = words[rd_dev];
endmodule

// File: rtl/pata_phase_seq.sv
module pata_phase_seq
  import pata_strobe_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  phase_t           ph_in,
  input  logic [CNT_W-1:0] count_in,
  output logic             strobe_on,
  output logic             deassert,
  output logic             load_act,
  output logic             busy,
  output logic             done
);
  seq_state_t       state_q, state_n;
  logic [TMR_W-1:0] tmr_q, tmr_n;
  logic [CNT_W-1:0] left_q, left_n;
  phase_t           ph_q;

  always_comb begin
    state_n = state_q;
    tmr_n   = tmr_q;
    left_n  = left_q;
    unique case (state_q)
      SQ_IDLE: if (start) begin
        left_n = (count_in == '0) ? '0 : count_in - 1'b1;
        if (ph_in.setup != '0) begin
          state_n = SQ_SETUP;
          tmr_n   = TMR_W'(ph_in.setup) - 1'b1;
        end else begin
          state_n = SQ_ACTIVE;
          tmr_n   = TMR_W'(ph_in.act);
        end
      end
      SQ_SETUP: if (tmr_q == '0) begin
        state_n = SQ_ACTIVE;
        tmr_n   = TMR_W'(ph_q.act);
      end else tmr_n = tmr_q - 1'b1;
      SQ_ACTIVE: if (tmr_q == '0) begin
        state_n = SQ_RECOV;
        tmr_n   = TMR_W'(ph_q.rec);
      end else tmr_n = tmr_q - 1'b1;
      SQ_RECOV: if (tmr_q == '0) begin
        if (left_q == '0) state_n = SQ_DONE;
        else begin
          state_n = SQ_ACTIVE;
          tmr_n   = TMR_W'(ph_q.act);
          left_n  = left_q - 1'b1;
        end
      end else tmr_n = tmr_q - 1'b1;
      SQ_DONE: state_n = SQ_IDLE;
      default: state_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      tmr_q   <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_n;
      tmr_q   <= tmr_n;
      left_q  <= left_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= '0;
    else if (start) ph_q <= ph_in;
  end

  assign strobe_on = (state_q == SQ_ACTIVE);
  assign deassert  = (state_q == SQ_ACTIVE) && (tmr_q == '0);
  assign load_act  = (state_n == SQ_ACTIVE) && (state_q != SQ_ACTIVE);
  assign busy      = (state_q != SQ_IDLE);
  assign done      = (state_q == SQ_DONE);
endmodule

// File: rtl/pata_strobe_gen.sv
module pata_strobe_gen
  import pata_strobe_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int CNT_W   = 8,
  parameter int DW      = 16,
  localparam int DEV_W  = $clog2(NUM_DEV)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [DEV_W-1:0]     cfg_dev,
  input  logic [31:0]          cfg_word,
  output logic [4*NUM_DEV-1:0] flags_o,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_data,
  input  logic                 req_dma,
  input  logic [DEV_W-1:0]     req_dev,
  input  logic [CNT_W-1:0]     req_count,
  input  logic [2:0]           req_addr,
  input  logic                 req_csel,
  input  logic [DW-1:0]        req_wdata,
  output logic                 busy,
  output logic                 rsp_done,
  output logic                 rsp_rvalid,
  output logic [DW-1:0]        rsp_rdata,
  output logic                 fifo_on,
  output logic [2:0]           ata_addr,
  output logic [1:0]           ata_cs_n,
  output logic                 ata_rd_n,
  output logic                 ata_wr_n,
  output logic [DW-1:0]        ata_dout,
  output logic                 ata_doe,
  input  logic [DW-1:0]        ata_din
);
  logic [31:0] sel_word;
  phase_t      sel_phase;
  logic        start, strobe_on, deassert, load_act;
  logic        wr_q, data_q, dma_q;
  logic [2:0]  addr_q;
  logic [1:0]  csn_q;
  logic [DW-1:0] dout_q, rdata_q;
  logic        rvalid_q;

  pata_timing_bank #(.NUM_DEV(NUM_DEV)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dev(cfg_dev), .cfg_word(cfg_word),
    .rd_dev(req_dev), .rd_word(sel_word), .flags(flags_o)
  );

  assign sel_phase = pick_phase(sel_word, req_data);
  assign start     = req_valid && !busy;

  pata_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ph_in(sel_phase), .count_in(req_count),
    .strobe_on(strobe_on), .deassert(deassert), .load_act(load_act),
    .busy(busy), .done(rsp_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      data_q <= 1'b0;
      dma_q  <= 1'b0;
      addr_q <= '0;
      csn_q  <= 2'b11;
    end else if (start) begin
      wr_q   <= req_write;
      data_q <= req_data;
      dma_q  <= req_dma;
      addr_q <= req_data ? 3'd0 : req_addr;
      csn_q  <= (!req_data && req_csel) ? 2'b01 : 2'b10;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dout_q <= '0;
    else if (load_act) dout_q <= req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rdata_q <= '0;
    else if (deassert && !wr_q)  rdata_q <= ata_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= deassert && !wr_q;
  end

  assign rsp_rdata  = rdata_q;
  assign rsp_rvalid = rvalid_q;
  assign fifo_on    = busy && data_q && dma_q;
  assign ata_rd_n   = !(strobe_on && !wr_q);
  assign ata_wr_n   = !(strobe_on && wr_q);
  assign ata_cs_n   = busy ? csn_q : 2'b11;
  assign ata_addr   = busy ? addr_q : 3'd0;
  assign ata_dout   = dout_q;
  assign ata_doe    = busy && wr_q;
endmodule

// File: rtl/pata_strobe_chk.sv
module pata_strobe_chk #(
  parameter int NUM_DEV = 2,
  parameter int DW      = 16,
  localparam int DEV_W  = $clog2(NUM_DEV)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_we,
  input logic [DEV_W-1:0]     cfg_dev,
  input logic [31:0]          cfg_word,
  input logic [4*NUM_DEV-1:0] flags_o,
  input logic                 busy,
  input logic                 rsp_done,
  input logic                 rsp_rvalid,
  input logic                 fifo_on,
  input logic [1:0]           ata_cs_n,
  input logic                 ata_rd_n,
  input logic                 ata_wr_n
);
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_rd_n && !ata_wr_n));
  p_strobe_has_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_rd_n || !ata_wr_n) |-> ($countones(ata_cs_n) == 1));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_done_after_recov_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (ata_rd_n && ata_wr_n && $past(ata_rd_n) && $past(ata_wr_n)));
  p_fifo_in_burst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_on |-> busy);
  p_flags_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_dev == '0) |=> (flags_o[3:0] == $past(cfg_word[31:28])));
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ata_cs_n == 2'b11 && ata_rd_n && ata_wr_n && !rsp_done));
  p_rvalid_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rvalid |-> (ata_rd_n && $past(!ata_rd_n)));
endmodule

bind pata_strobe_gen pata_strobe_chk #(.NUM_DEV(NUM_DEV), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dev(cfg_dev), .cfg_word(cfg_word),
  .flags_o(flags_o), .busy(busy), .rsp_done(rsp_done), .rsp_rvalid(rsp_rvalid),
  .fifo_on(fifo_on), .ata_cs_n(ata_cs_n), .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n)
);

// File: tb/pata_strobe_gen_bench.sv
`timescale 1ns/1ps
module pata_strobe_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_dev = '0;
  logic [31:0] cfg_word = '0;
  logic [7:0]  flags_o;
  logic        req_valid = 1'b0, req_write = 1'b0, req_data = 1'b0, req_dma = 1'b0;
  logic [0:0]  req_dev = '0;
  logic [7:0]  req_count = '0;
  logic [2:0]  req_addr = '0;
  logic        req_csel = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        busy, rsp_done, rsp_rvalid, fifo_on;
  logic [15:0] rsp_rdata, ata_dout;
  logic [15:0] ata_din = '0;
  logic [2:0]  ata_addr;
  logic [1:0]  ata_cs_n;
  logic        ata_rd_n, ata_wr_n, ata_doe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pata_strobe_gen u_pata_strobe_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dev(cfg_dev), .cfg_word(cfg_word),
    .flags_o(flags_o), .req_valid(req_valid), .req_write(req_write), .req_data(req_data),
    .req_dma(req_dma), .req_dev(req_dev), .req_count(req_count), .req_addr(req_addr),
    .req_csel(req_csel), .req_wdata(req_wdata), .busy(busy), .rsp_done(rsp_done),
    .rsp_rvalid(rsp_rvalid), .rsp_rdata(rsp_rdata), .fifo_on(fifo_on), .ata_addr(ata_addr),
    .ata_cs_n(ata_cs_n), .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n), .ata_dout(ata_dout),
    .ata_doe(ata_doe), .ata_din(ata_din)
  );

  typedef struct packed {
    logic [3:0] flags;
    logic [2:0] rs;
    logic [2:0] ds;
    logic [4:0] ca;
    logic [3:0] ch;
    logic [4:0] da;
    logic [3:0] dh;
    logic       wr;
    logic       dt;
    logic       dma;
    logic       dev;
    logic [3:0] cnt;
    logic [2:0] addr;
    logic       csel;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{4'hC, 3'd2, 3'd1, 5'd3,  4'd2,  5'd4,  4'd1,  1'b0, 1'b1, 1'b0, 1'b0, 4'd1, 3'd0, 1'b0},
    '{4'hA, 3'd0, 3'd3, 5'd1,  4'd1,  5'd2,  4'd0,  1'b1, 1'b1, 1'b1, 1'b1, 4'd3, 3'd0, 1'b0},
    '{4'h9, 3'd3, 3'd0, 5'd5,  4'd3,  5'd1,  4'd1,  1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 3'd7, 1'b0},
    '{4'h0, 3'd1, 3'd2, 5'd0,  4'd0,  5'd0,  4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 4'd1, 3'd6, 1'b1},
    '{4'h5, 3'd7, 3'd7, 5'd31, 4'd15, 5'd31, 4'd15, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2, 3'd0, 1'b0},
    '{4'h3, 3'd0, 3'd0, 5'd2,  4'd1,  5'd0,  4'd0,  1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 3'd0, 1'b0},
    '{4'hF, 3'd4, 3'd5, 5'd6,  4'd7,  5'd3,  4'd2,  1'b0, 1'b1, 1'b0, 1'b1, 4'd4, 3'd0, 1'b0}
  };

  function automatic logic [31:0] mk(input logic [3:0] fl, input logic [2:0] rs, input logic [2:0] ds,
                                     input logic [4:0] ca, input logic [3:0] ch,
                                     input logic [4:0] da, input logic [3:0] dh);
    return {fl, rs, ds, 4'h0, ca, ch, da, dh};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic dv, input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dev = dv; cfg_word = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Issues one request and observes the pins on falling edges until done.
  task automatic run_req(input logic wr, input logic dt, input logic dma, input logic dv,
                         input logic [7:0] cnt, input logic [2:0] ad, input logic cs,
                         input logic [15:0] wd, input logic mid_we, input logic [31:0] mid_word,
                         output int first_low, output int low_len, output int pulses,
                         output int done_cyc, output int rv_cnt, output logic fifo_seen,
                         output logic pin_bad, output logic [15:0] exp_rd);
    int cyc;
    logic prev_low, in_first, s_low, o_low;
    logic [1:0] exp_cs;
    logic [2:0] exp_ad;
    first_low = -1; low_len = 0; pulses = 0; rv_cnt = 0;
    fifo_seen = 1'b0; pin_bad = 1'b0; exp_rd = '0;
    exp_cs = (!dt && cs) ? 2'b01 : 2'b10;
    exp_ad = dt ? 3'd0 : ad;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_data = dt; req_dma = dma; req_dev = dv;
    req_count = cnt; req_addr = ad; req_csel = cs; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0; prev_low = 1'b0; in_first = 1'b0;
    while (!rsp_done && cyc < 4000) begin
      s_low = wr ? !ata_wr_n : !ata_rd_n;
      o_low = wr ? !ata_rd_n : !ata_wr_n;
      if (o_low || ata_cs_n != exp_cs || ata_addr != exp_ad || ata_doe != wr || !busy) pin_bad = 1'b1;
      if (wr && s_low && ata_dout != wd) pin_bad = 1'b1;
      if (fifo_on) fifo_seen = 1'b1;
      if (rsp_rvalid) rv_cnt++;
      cfg_we = (mid_we && cyc == 1);
      cfg_dev = dv; cfg_word = mid_word;
      ata_din = 16'h5A00 ^ 16'(cyc * 37);
      if (s_low) begin
        if (first_low < 0) begin first_low = cyc; in_first = 1'b1; end
        if (in_first) low_len++;
        if (!prev_low) pulses++;
        exp_rd = ata_din;
      end else in_first = 1'b0;
      prev_low = s_low;
      @(negedge clk);
      cyc++;
    end
    cfg_we = 1'b0;
    done_cyc = cyc;
    @(negedge clk);
    chk(!rsp_done && !busy, "R2 done lasts one cycle", int'(rsp_done), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int fl, ll, pu, dc, rv, s, a, h, n;
    logic fs, pb;
    logic [15:0] er;
    logic [31:0] wa, wb;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R13: reset state of the pins and flags
    chk(ata_rd_n && ata_wr_n, "R13 strobes high in reset", int'({ata_rd_n, ata_wr_n}), 3);
    chk(ata_cs_n == 2'b11 && !busy && !rsp_done && !rsp_rvalid && !fifo_on,
        "R13 idle outputs in reset", int'(ata_cs_n), 3);
    chk(flags_o == 8'h00, "R13 timing words reset to zero", int'(flags_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VECS[i];
      cfg_write(v.dev, mk(v.flags, v.rs, v.ds, v.ca, v.ch, v.da, v.dh));
      chk(flags_o[4*v.dev +: 4] == v.flags, "R7 flags follow word", int'(flags_o[4*v.dev +: 4]), int'(v.flags));
      s = v.dt ? int'(v.ds) : int'(v.rs);
      a = v.dt ? int'(v.da) : int'(v.ca);
      h = v.dt ? int'(v.dh) : int'(v.ch);
      n = (v.cnt == 0) ? 1 : int'(v.cnt);
      run_req(v.wr, v.dt, v.dma, v.dev, 8'(v.cnt), v.addr, v.csel, 16'hC3A0 + 16'(i),
              1'b0, 32'h0, fl, ll, pu, dc, rv, fs, pb, er);
      if (v.dt) begin
        chk(fl == s, "R4 data setup before first strobe", fl, s);
        chk(ll == a + 1, "R1 data strobe active time", ll, a + 1);
        chk(dc == s + n * (a + h + 2), "R2 data recovery and done timing", dc, s + n * (a + h + 2));
      end else begin
        chk(fl == s, "R5 register setup", fl, s);
        chk(ll == a + 1, "R3 register active time", ll, a + 1);
        chk(dc == s + n * (a + h + 2), "R3 register recovery and done timing", dc, s + n * (a + h + 2));
      end
      chk(pu == n, "R8 strobe count", pu, n);
      chk(fs == (v.dt && v.dma), "R10 fifo only in DMA data bursts", int'(fs), int'(v.dt && v.dma));
      chk(!pb, "R12 address, chip select and data pins", int'(pb), 0);
      if (!v.wr) begin
        chk(rsp_rdata == er, "R9 read data captured at strobe rise", int'(rsp_rdata), int'(er));
        chk(rv == n, "R9 one rvalid per word", rv, n);
      end
    end

    // R6: each device keeps its own word and req_dev picks it
    wa = mk(4'h1, 3'd0, 3'd0, 5'd9, 4'd0, 5'd2, 4'd1);
    wb = mk(4'h2, 3'd0, 3'd0, 5'd9, 4'd0, 5'd6, 4'd0);
    cfg_write(1'b0, wa);
    cfg_write(1'b1, wb);
    chk(flags_o == 8'h21, "R6 write touches one device only", int'(flags_o), 'h21);
    run_req(1'b0, 1'b1, 1'b0, 1'b0, 8'd1, 3'd0, 1'b0, 16'h0, 1'b0, 32'h0, fl, ll, pu, dc, rv, fs, pb, er);
    chk(ll == 3, "R6 device 0 timing used", ll, 3);
    run_req(1'b0, 1'b1, 1'b0, 1'b1, 8'd1, 3'd0, 1'b0, 16'h0, 1'b0, 32'h0, fl, ll, pu, dc, rv, fs, pb, er);
    chk(ll == 7, "R6 device 1 timing used", ll, 7);

    // R11: mid-burst word write applies only from the next request
    run_req(1'b0, 1'b1, 1'b0, 1'b0, 8'd2, 3'd0, 1'b0, 16'h0, 1'b1, wb, fl, ll, pu, dc, rv, fs, pb, er);
    chk(dc == 2 * (2 + 1 + 2), "R11 running burst keeps old timing", dc, 10);
    run_req(1'b0, 1'b1, 1'b0, 1'b0, 8'd1, 3'd0, 1'b0, 16'h0, 1'b0, 32'h0, fl, ll, pu, dc, rv, fs, pb, er);
    chk(ll == 7, "R11 next request uses new word", ll, 7);

    // R13: idle after activity
    chk(ata_cs_n == 2'b11 && ata_rd_n && ata_wr_n && !fifo_on, "R13 idle pins", int'(ata_cs_n), 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule